// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block sits between a byte-wide CPU I/O bus and the core of a floppy disk controller. It decodes 3-bit port offsets and provides a write-only drive/motor control register, a read-only main status register, one shared data port, a write-only data-rate register and a read-only input register that shows the disk-change and density lines.

Every command runs in three phases. In the command phase the CPU writes the opcode and its parameter bytes through the data port. In the execution phase an internal stub stands in for the disk engine: it finishes after a fixed number of cycles and hands back result bytes. In the result phase the CPU reads those bytes through the same data port. Software paces the transfer by polling a ready bit and a direction bit in the main status register. An interrupt flags the end of execution. A bit in the control register holds the sequencer idle, and clearing that bit aborts any command in flight.

Top module: `fdc_host_regs`

## Requirements
- R1: A write to offset 2 loads the control register. Bits 1:0 drive `drive_sel_o`. Bit 2 = 1 lets the sequencer run. Bit 3 drives `dma_en_o` and enables the interrupt. Bits 7:4 drive `motor_en_o`.
- R2: After `rst_ni` the control register and the data-rate register are zero. A read of offset 4 then returns 0x00, and `irq_o` is 0.
- R3: While control bit 2 is 0, offset 4 reads 0x00 and writes to the data port are ignored. Clearing bit 2 during a command aborts it and drops the interrupt. After bit 2 is set again, offset 4 reads 0x80.
- R4: Layout of the main status register at offset 4. Bit 7 = data port ready. Bit 6 = direction (1 = result bytes to the CPU). Bit 4 = command busy. Bit 5 = 1 during execution when control bit 3 is 0. Bits 3:0 = seek-busy flag of the drive being recalibrated.
- R5: Opcode bits 4:0 = 0x04 (bits 7:5 ignored) is a sense-drive-status command. It takes 2 bytes. After the first byte, offset 4 reads 0x90. Its single result is 0x38 | (parameter & 7).
- R6: Opcode bits 4:0 = 0x07 is a recalibrate command. It takes 2 bytes. During execution, bit u of offset 4 is set, where u = parameter bits 1:0. Its results are 0x20 | u, then 0x00.
- R7: Any other opcode skips execution. Offset 4 reads 0xD0 at once, one result byte 0x80 is returned, and no interrupt is raised.
- R8: When execution ends and control bit 3 is 1, `irq_o` goes to 1 and the result phase starts (offset 4 reads 0xD0). With bit 3 = 0, `irq_o` stays 0. The first data-port read in the result phase clears the interrupt.
- R9: A data-port write during execution or during the result phase is ignored. It changes neither the phase nor the result bytes.
- R10: After the last result byte is read, offset 4 reads 0x80.
- R11: A write to offset 7 sets `rate_sel_o` to bits 1:0 of the written byte. A read of offset 7 returns {`disk_change_i`, 000000, `high_density_i`}.
- R12: A data-port read outside the result phase returns 0x00 and changes nothing. Reads of offsets 0, 1, 2, 3 and 6 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Port offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| rdata_o | output | 8 | Read data for the current offset |
| irq_o | output | 1 | End-of-execution interrupt |
| drive_sel_o | output | 2 | Selected drive |
| motor_en_o | output | 4 | Motor enables, drives 0-3 |
| dma_en_o | output | 1 | DMA/interrupt enable |
| rate_sel_o | output | 2 | Data-rate code (00 = 500 kbit/s, 10 = 250 kbit/s) |
| disk_change_i | input | 1 | Disk-change line |
| high_density_i | input | 1 | Density line |

## Verification
A table of command runs covers the following patterns:
- Both supported opcodes, and one of them again with its upper opcode bits set. This separates a 5-bit opcode decode from a full-byte decode.
- Different parameter bytes. These show whether the unit and head fields reach the results and the seek flags.
- The interrupt enable on and off. This splits the interrupt path from the non-DMA status bit.
- An unknown opcode. This proves the execution phase is skipped.

Directed runs then cover the remaining corner cases:
- Data-port writes during execution and during the result phase.
- A core hold during execution.
- Data-port reads while no result is pending.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_DRIVES = 4;
  localparam int unsigned UNIT_W     = $clog2(NUM_DRIVES);
  localparam int unsigned RATE_W     = 2;
  localparam int unsigned RES_MAX    = 2;
  localparam int unsigned RES_IW     = $clog2(RES_MAX);
  localparam int unsigned RES_CW     = $clog2(RES_MAX + 1);
  localparam int unsigned LEN_W      = 2;

  localparam logic [2:0] OFF_DRV  = 3'd2;
  localparam logic [2:0] OFF_MSR  = 3'd4;
  localparam logic [2:0] OFF_DATA = 3'd5;
  localparam logic [2:0] OFF_RATE = 3'd7;

  localparam logic [BYTE_W-1:0] ST0_INVALID = 8'h80;
  localparam logic [BYTE_W-1:0] ST0_SEEKEND = 8'h20;
  localparam logic [BYTE_W-1:0] ST3_BASE    = 8'h38;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_e;
  typedef enum logic [1:0] {OP_BAD, OP_SENSE_DRV, OP_RECAL} op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [LEN_W-1:0]  cmd_len;
    logic [RES_CW-1:0] res_len;
  } op_desc_t;
endpackage

// File: rtl/fdc_cmd_table.sv
module fdc_cmd_table
  import fdc_host_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode_i,
  output op_desc_t          desc_o
);
  // only the low five opcode bits select the command
  always_comb begin
    unique case (opcode_i[4:0])
      5'h04:   desc_o = '{kind: OP_SENSE_DRV, cmd_len: LEN_W'(2), res_len: RES_CW'(1)};
      5'h07:   desc_o = '{kind: OP_RECAL,     cmd_len: LEN_W'(2), res_len: RES_CW'(2)};
      default: desc_o = '{kind: OP_BAD,       cmd_len: LEN_W'(1), res_len: RES_CW'(1)};
    endcase
  end
endmodule

// File: rtl/fdc_exec_stub.sv
module fdc_exec_stub
  import fdc_host_pkg::*;
#(
  parameter int unsigned EXEC_CYCLES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  start_i,
  input  op_kind_e              kind_i,
  input  logic [2:0]            arg_i,
  output logic                  done_o,
  output logic [BYTE_W-1:0]     res0_o,
  output logic [BYTE_W-1:0]     res1_o,
  output logic [NUM_DRIVES-1:0] seek_o
);
  localparam int unsigned CNT_W = $clog2(EXEC_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, done_q;
  op_kind_e          kind_q;
  logic [2:0]        arg_q;
  logic [BYTE_W-1:0] res0_q, res1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      kind_q <= OP_BAD;
      arg_q  <= '0;
      res0_q <= '0;
      res1_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= CNT_W'(EXEC_CYCLES);
        kind_q <= kind_i;
        arg_q  <= arg_i;
      end else if (run_q) begin
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          unique case (kind_q)
            OP_SENSE_DRV: begin
              res0_q <= ST3_BASE | {5'b0, arg_q};
              res1_q <= '0;
            end
            OP_RECAL: begin
              res0_q <= ST0_SEEKEND | {{(BYTE_W-UNIT_W){1'b0}}, arg_q[UNIT_W-1:0]};
              res1_q <= '0;
            end
            default: begin
              res0_q <= ST0_INVALID;
              res1_q <= '0;
            end
          endcase
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_seek
    assign seek_o[g] = run_q && (kind_q == OP_RECAL) && (arg_q[UNIT_W-1:0] == UNIT_W'(g));
  end

  assign done_o = done_q;
  assign res0_o = res0_q;
  assign res1_o = res1_q;
endmodule

// File: rtl/fdc_ctrl_regs.sv
module fdc_ctrl_regs
  import fdc_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] dor_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [BYTE_W-1:0] dor_q;
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dor_q  <= '0;
      rate_q <= '0;
    end else if (wr_i) begin
      if (addr_i == OFF_DRV)  dor_q  <= wdata_i;
      if (addr_i == OFF_RATE) rate_q <= wdata_i[RATE_W-1:0];
    end
  end

  assign dor_o  = dor_q;
  assign rate_o = rate_q;
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_host_pkg::*;
#(
  parameter int unsigned EXEC_CYCLES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [BYTE_W-1:0]     rdata_o,
  output logic                  irq_o,
  output logic [UNIT_W-1:0]     drive_sel_o,
  output logic [NUM_DRIVES-1:0] motor_en_o,
  output logic                  dma_en_o,
  output logic [RATE_W-1:0]     rate_sel_o,
  input  logic                  disk_change_i,
  input  logic                  high_density_i
);
  logic [BYTE_W-1:0]     dor_q;
  logic                  core_en, irq_en;
  op_desc_t              desc;
  phase_e                phase_q;
  logic [LEN_W-1:0]      cmd_cnt_q, cmd_len_q;
  op_kind_e              kind_q, start_kind;
  logic [RES_CW-1:0]     res_len_q, res_cnt_q;
  logic [RES_IW-1:0]     res_idx_q;
  logic [BYTE_W-1:0]     res_buf_q [RES_MAX];
  logic                  irq_q;
  logic                  data_wr, data_rd, accept_wr, pop, first, start;
  logic                  stub_done;
  logic [BYTE_W-1:0]     stub_res0, stub_res1;
  logic [NUM_DRIVES-1:0] seek;
  logic [BYTE_W-1:0]     msr;

  fdc_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .dor_o   (dor_q),
    .rate_o  (rate_sel_o)
  );

  assign core_en     = dor_q[2];
  assign irq_en      = dor_q[3];
  assign drive_sel_o = dor_q[UNIT_W-1:0];
  assign dma_en_o    = dor_q[3];
  assign motor_en_o  = dor_q[4 +: NUM_DRIVES];

  fdc_cmd_table u_table (
    .opcode_i (wdata_i),
    .desc_o   (desc)
  );

  assign data_wr   = wr_i && (addr_i == OFF_DATA);
  assign data_rd   = rd_i && (addr_i == OFF_DATA);
  assign accept_wr = data_wr && core_en && (phase_q == PH_CMD);
  assign pop       = data_rd && core_en && (phase_q == PH_RES);
  assign first     = (cmd_cnt_q == '0);
  assign start_kind = first ? desc.kind : kind_q;

  always_comb begin
    start = 1'b0;
    if (accept_wr) begin
      if (first) start = (desc.kind != OP_BAD) && (desc.cmd_len == LEN_W'(1));
      else       start = ((cmd_cnt_q + LEN_W'(1)) == cmd_len_q);
    end
  end

  fdc_exec_stub #(.EXEC_CYCLES(EXEC_CYCLES)) u_stub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!core_en),
    .start_i (start),
    .kind_i  (start_kind),
    .arg_i   (wdata_i[2:0]),
    .done_o  (stub_done),
    .res0_o  (stub_res0),
    .res1_o  (stub_res1),
    .seek_o  (seek)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      cmd_cnt_q <= '0;
      cmd_len_q <= '0;
      kind_q    <= OP_BAD;
      res_len_q <= '0;
      res_cnt_q <= '0;
      res_idx_q <= '0;
      irq_q     <= 1'b0;
      for (int i = 0; i < RES_MAX; i++) res_buf_q[i] <= '0;
    end else if (!core_en) begin
      phase_q   <= PH_CMD;
      cmd_cnt_q <= '0;
      res_idx_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_CMD: if (accept_wr) begin
          if (first && desc.kind == OP_BAD) begin
            res_buf_q[0] <= ST0_INVALID;
            res_cnt_q    <= RES_CW'(1);
            res_idx_q    <= '0;
            phase_q      <= PH_RES;
          end else begin
            if (first) begin
              cmd_len_q <= desc.cmd_len;
              kind_q    <= desc.kind;
              res_len_q <= desc.res_len;
            end
            if (start) begin
              phase_q   <= PH_EXEC;
              cmd_cnt_q <= '0;
            end else begin
              cmd_cnt_q <= cmd_cnt_q + LEN_W'(1);
            end
          end
        end
        PH_EXEC: if (stub_done) begin
          res_buf_q[0] <= stub_res0;
          res_buf_q[1] <= stub_res1;
          res_cnt_q    <= res_len_q;
          res_idx_q    <= '0;
          irq_q        <= 1'b1;
          phase_q      <= PH_RES;
        end
        PH_RES: if (pop) begin
          irq_q <= 1'b0;
          if ((RES_CW'(res_idx_q) + RES_CW'(1)) == res_cnt_q) begin
            phase_q   <= PH_CMD;
            res_idx_q <= '0;
          end else begin
            res_idx_q <= res_idx_q + RES_IW'(1);
          end
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  always_comb begin
    msr = '0;
    if (core_en) begin
      unique case (phase_q)
        PH_CMD:  msr = {1'b1, 1'b0, 1'b0, !first, {NUM_DRIVES{1'b0}}};
        PH_EXEC: msr = {1'b0, 1'b0, !irq_en, 1'b1, seek};
        PH_RES:  msr = {1'b1, 1'b1, 1'b0, 1'b1, {NUM_DRIVES{1'b0}}};
        default: msr = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_MSR:  rdata_o = msr;
      OFF_DATA: rdata_o = (core_en && phase_q == PH_RES) ? res_buf_q[res_idx_q] : '0;
      OFF_RATE: rdata_o = {disk_change_i, 6'b0, high_density_i};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q && irq_en && core_en;
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk
  import fdc_host_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              core_en_i,
  input logic [BYTE_W-1:0] msr_i,
  input logic              irq_i
);
  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_en_i) |=> (msr_i == 8'h00));

  assert_hold_drops_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_en_i) |=> ##1 !irq_i);

  assert_irq_in_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && core_en_i) |-> msr_i[6]);

  assert_irq_after_exec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(msr_i[4] && !msr_i[7]));

  assert_first_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_DATA && msr_i[6]) |=> !irq_i);

  assert_result_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == OFF_DATA && msr_i[6]) |=> $stable(msr_i));
endmodule

bind fdc_host_regs fdc_host_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .core_en_i (core_en),
  .msr_i     (msr),
  .irq_i     (irq_q)
);

// File: tb/fdc_host_regs_tb.sv
`timescale 1ns/1ps
module fdc_host_regs_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] drive_sel;
  logic [3:0] motor_en;
  logic       dma_en;
  logic [1:0] rate_sel;
  logic       disk_change = 1'b0, high_density = 1'b0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fdc_host_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .irq_o(irq), .drive_sel_o(drive_sel), .motor_en_o(motor_en),
    .dma_en_o(dma_en), .rate_sel_o(rate_sel), .disk_change_i(disk_change),
    .high_density_i(high_density)
  );

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] arg;
    logic       dma;
    logic       bad;
    logic [1:0] nres;
    logic [7:0] r0;
    logic [7:0] r1;
    logic       irq;
    logic [3:0] seek;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 8'h05, 1'b1, 1'b0, 2'd1, 8'h3D, 8'h00, 1'b1, 4'h0},
    '{8'hC4, 8'h02, 1'b1, 1'b0, 2'd1, 8'h3A, 8'h00, 1'b1, 4'h0},
    '{8'h07, 8'h01, 1'b1, 1'b0, 2'd2, 8'h21, 8'h00, 1'b1, 4'h2},
    '{8'h07, 8'h03, 1'b0, 1'b0, 2'd2, 8'h23, 8'h00, 1'b0, 4'h8},
    '{8'h1F, 8'h00, 1'b1, 1'b1, 2'd1, 8'h80, 8'h00, 1'b0, 4'h0},
    '{8'h04, 8'h07, 1'b0, 1'b0, 2'd1, 8'h3F, 8'h00, 1'b0, 4'h0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_ready(output logic [7:0] m);
    m = 8'h00;
    for (int k = 0; k < 50; k++) begin
      bus_read(3'd4, m);
      if (m[7]) break;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] m, d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2 reset state
    bus_read(3'd4, m);
    chk("R2 msr", m, 8'h00);
    chk("R2 irq", {7'b0, irq}, 8'h00);
    chk("R2 dor", {motor_en, 1'b0, dma_en, drive_sel}, 8'h00);
    chk("R2 rate", {6'b0, rate_sel}, 8'h00);

    // R3 data write ignored while held
    bus_write(3'd5, 8'h04);
    bus_read(3'd4, m);
    chk("R3 held msr", m, 8'h00);
    bus_write(3'd2, 8'h04);
    bus_read(3'd4, m);
    chk("R3 release msr", m, 8'h80);

    // R1 control register fields
    bus_write(3'd2, 8'hA6);
    chk("R1 drive_sel", {6'b0, drive_sel}, 8'h02);
    chk("R1 motor_en", {4'b0, motor_en}, 8'h0A);
    chk("R1 dma_en", {7'b0, dma_en}, 8'h00);
    bus_read(3'd4, m);
    chk("R1 core run", m, 8'h80);

    // R11 rate and input registers
    bus_write(3'd7, 8'h02);
    chk("R11 rate 250k", {6'b0, rate_sel}, 8'h02);
    bus_write(3'd7, 8'hFD);
    chk("R11 rate low bits", {6'b0, rate_sel}, 8'h01);
    disk_change = 1'b1; high_density = 1'b0;
    bus_read(3'd7, d);
    chk("R11 input chg", d, 8'h80);
    disk_change = 1'b0; high_density = 1'b1;
    bus_read(3'd7, d);
    chk("R11 input hd", d, 8'h01);

    // R12 idle data read and unused offsets
    bus_read(3'd5, d);
    chk("R12 idle data", d, 8'h00);
    bus_read(3'd4, m);
    chk("R12 msr unchanged", m, 8'h80);
    bus_read(3'd0, d);
    chk("R12 offset0", d, 8'h00);
    bus_read(3'd6, d);
    chk("R12 offset6", d, 8'h00);

    // table-driven command runs: R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      bus_write(3'd2, VECS[i].dma ? 8'h0C : 8'h04);
      bus_write(3'd5, VECS[i].op);
      if (VECS[i].bad) begin
        bus_read(3'd4, m);
        chk("R7 invalid msr", m, 8'hD0);
        chk("R7 no irq", {7'b0, irq}, 8'h00);
      end else begin
        bus_read(3'd4, m);
        chk("R5 after first byte", m, 8'h90);
        bus_write(3'd5, VECS[i].arg);
        bus_read(3'd4, m);
        chk("R4 R6 exec msr", m, {2'b00, ~VECS[i].dma, 1'b1, VECS[i].seek});
        wait_ready(m);
        chk("R8 result msr", m, 8'hD0);
        chk("R8 irq level", {7'b0, irq}, {7'b0, VECS[i].irq});
      end
      bus_read(3'd5, d);
      chk("R5 R6 R7 result0", d, VECS[i].r0);
      chk("R8 irq cleared", {7'b0, irq}, 8'h00);
      if (VECS[i].nres == 2'd2) begin
        bus_read(3'd4, m);
        chk("R6 second pending", m, 8'hD0);
        bus_read(3'd5, d);
        chk("R6 result1", d, VECS[i].r1);
      end
      bus_read(3'd4, m);
      chk("R10 back to idle", m, 8'h80);
    end

    // R9 writes during execution and result phases
    bus_write(3'd2, 8'h0C);
    bus_write(3'd5, 8'h04);
    bus_write(3'd5, 8'h01);
    bus_write(3'd5, 8'h07);
    wait_ready(m);
    chk("R9 exec write ignored", m, 8'hD0);
    bus_write(3'd5, 8'h55);
    bus_read(3'd4, m);
    chk("R9 result write msr", m, 8'hD0);
    bus_read(3'd5, d);
    chk("R9 result intact", d, 8'h39);
    bus_read(3'd4, m);
    chk("R9 R10 idle", m, 8'h80);

    // R3 abort during execution
    bus_write(3'd5, 8'h07);
    bus_write(3'd5, 8'h02);
    bus_write(3'd2, 8'h08);
    bus_read(3'd4, m);
    chk("R3 abort msr", m, 8'h00);
    repeat (10) @(negedge clk);
    chk("R3 abort irq", {7'b0, irq}, 8'h00);
    bus_write(3'd2, 8'h0C);
    bus_read(3'd4, m);
    chk("R3 restart msr", m, 8'h80);
    chk("R3 restart irq", {7'b0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule